// File: doc/BRIEF.md
# Write Completion Poller

This block sits on the host side of a byte-wide flash device. Once software has started a program or erase cycle in the device, the poller finds out when that cycle has ended. It issues read requests to a bus master, looks at the bytes that come back, and reports completion with a one-cycle pulse. The completion test is picked per run from three methods. The first compares the most significant data bit with its expected value, since the device returns it inverted while busy. The second watches bit 6, which the device flips on every read while busy. The third waits until two consecutive reads return the same byte.

The device finishes at a time that has no relation to the host's reads, so a single read can show a misleading picture. When a check fails, the poller takes two more confirming reads. It accepts completion only when both of them pass. If either fails, it goes back to ordinary polling. A cycle counter bounds every run and raises a timeout pulse if completion never shows up. The default limit is two million cycles, which covers a 20 ms whole-array erase at 100 MHz. The bit-7 method gives a correct answer only on a location that was erased before it was programmed. The caller is responsible for that.

Top module: `eow_poller`

## Requirements
- R1: After reset `busy`, `done`, `timeout` and `rd_valid` are all low, and `rd_valid` stays low whenever `busy` is low.
- R2: With `method` = 0, a read passes when its bit 7 equals bit 7 of `exp_data`. A pass on an ordinary read ends the run.
- R3: With `method` = 1, the first read of a run is only a baseline. Every later read passes when its bit 6 equals bit 6 of the read before it.
- R4: With `method` = 2 or 3, the first read is a baseline. Every later read passes when all 8 bits equal the read before it.
- R5: After an ordinary read fails its check, exactly two confirming reads follow, each checked in the same way. The run ends as done only if both pass. Otherwise ordinary polling resumes, and the last confirming read becomes the new predecessor.
- R6: Every read request carries `tgt_addr` as captured at start. `rd_valid` with a stable `rd_addr` is held until `rd_ready` is seen. The only exception is a timeout, which withdraws the request. At most one read is outstanding.
- R7: `rsp_ready` is low only while a request is being offered. A response that arrives while the block is idle is accepted and dropped.
- R8: `done` and `timeout` are single-cycle pulses, they are never high together, and `busy` is already low in the cycle the pulse is seen.
- R9: If no completion is seen, `timeout` pulses in the clock cycle that follows the TIMEOUT_CYCLES-th rising edge after the edge that sampled `start`. If a completion arrives in the same cycle, `done` wins.
- R10: A `start` pulse while `busy` is high is ignored. The address, expected data and method of the running poll do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling, taken only when idle |
| tgt_addr | input | AW | Location last written, to be read back |
| exp_data | input | DW | Byte that was written, true data |
| method | input | 2 | 0 bit-7 compare, 1 bit-6 toggle, 2/3 successive match |
| busy | output | 1 | Poll in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Time limit reached without completion, pulse |
| rd_valid | output | 1 | Read request offered |
| rd_ready | input | 1 | Bus master takes the request |
| rd_addr | output | AW | Read address |
| rsp_valid | input | 1 | Read data present, held until taken |
| rsp_ready | output | 1 | Poller can take read data |
| rsp_data | input | DW | Read data |

## Verification
Each method is run against a device model that stays busy for a chosen number of reads: zero, one, and several. These cases separate a block that stops on the first passing read from one that wrongly confirms, and a block that skips confirmation from one that performs it. Busy counts with both parities matter for the toggle method. In one parity the last busy read shows the same bit 6 as the true data, which gives exactly the misleading match that the two confirming reads must absorb. A device that never finishes, and a second `start` issued in the middle of a run, cover the timeout and the ignore rule. The read master throttles requests on a fixed pattern throughout.

// File: rtl/eow_pkg.sv
package eow_pkg;
  typedef enum logic [1:0] {
    M_POLL   = 2'd0,
    M_TOGGLE = 2'd1,
    M_MATCH  = 2'd2,
    M_MATCH2 = 2'd3
  } method_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } state_e;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
endpackage

// File: rtl/eow_check.sv
module eow_check
  import eow_pkg::*;
#(
  parameter int DW = 8
) (
  input  method_e         method,
  input  logic [DW-1:0]   cur,
  input  logic [DW-1:0]   prev,
  input  logic [DW-1:0]   expected,
  output logic            pass,
  output logic            wants_base
);
  always_comb begin
    unique case (method)
      M_POLL:   pass = (cur[POLL_BIT] == expected[POLL_BIT]);
      M_TOGGLE: pass = (cur[TOGGLE_BIT] == prev[TOGGLE_BIT]);
      default:  pass = (cur == prev);
    endcase
    wants_base = (method != M_POLL);
  end
endmodule

// File: rtl/eow_timer.sv
module eow_timer #(
  parameter int LIMIT = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= LAST));
endmodule

// File: rtl/eow_poller.sv
module eow_poller
  import eow_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int TIMEOUT_CYCLES = 2000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] exp_data,
  input  logic [1:0]    method,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data
);
  state_e        state;
  method_e       lat_method;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_exp;
  logic [DW-1:0] prev_q;
  logic          have_prev;
  logic [1:0]    conf_cnt;
  logic          conf_ok;
  logic          done_q, tmo_q;
  logic          pass, wants_base, tmo_hit, rsp_fire, finish;

  assign busy      = (state != S_IDLE);
  assign rd_valid  = (state == S_REQ);
  assign rd_addr   = lat_addr;
  assign rsp_ready = (state != S_REQ);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign done      = done_q;
  assign timeout   = tmo_q;

  eow_check #(.DW(DW)) u_check (
    .method(lat_method), .cur(rsp_data), .prev(prev_q),
    .expected(lat_exp), .pass(pass), .wants_base(wants_base)
  );

  eow_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .expired(tmo_hit)
  );

  always_comb begin
    finish = 1'b0;
    if (state == S_WAIT && rsp_fire) begin
      if (conf_cnt == 2'd0) finish = !(wants_base && !have_prev) && pass;
      else if (conf_cnt == 2'd2) finish = conf_ok && pass;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      lat_method <= M_POLL;
      lat_addr   <= '0;
      lat_exp    <= '0;
      prev_q     <= '0;
      have_prev  <= 1'b0;
      conf_cnt   <= 2'd0;
      conf_ok    <= 1'b0;
      done_q     <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          lat_method <= method_e'(method);
          lat_addr   <= tgt_addr;
          lat_exp    <= exp_data;
          have_prev  <= 1'b0;
          conf_cnt   <= 2'd0;
          conf_ok    <= 1'b0;
          state      <= S_REQ;
        end
        S_REQ: begin
          if (tmo_hit) begin
            tmo_q <= 1'b1;
            state <= S_IDLE;
          end else if (rd_ready) begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (finish) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (tmo_hit) begin
            tmo_q <= 1'b1;
            state <= S_IDLE;
          end else if (rsp_fire) begin
            prev_q <= rsp_data;
            state  <= S_REQ;
            case (conf_cnt)
              2'd0: begin
                if (wants_base && !have_prev) have_prev <= 1'b1;
                else begin
                  conf_cnt <= 2'd1;
                  conf_ok  <= 1'b1;
                end
              end
              2'd1: begin
                conf_ok  <= pass;
                conf_cnt <= 2'd2;
              end
              default: conf_cnt <= 2'd0;
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid);
  assert_confirm_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conf_cnt != 2'd3);
  assert_hold_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !tmo_hit) |=> (rd_valid && $stable(rd_addr)));
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);
  assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(lat_addr) && $stable(lat_exp)));
endmodule

// File: tb/sim_eow_poller.sv
module sim_eow_poller;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int LIMIT = 300;
  localparam int NVEC = 11;

  typedef struct packed {
    logic [1:0]  m;
    logic [15:0] n;
    logic [7:0]  d;
    logic        ok;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    {2'd0, 16'd0,    8'hA5, 1'b1},
    {2'd0, 16'd1,    8'h3C, 1'b1},
    {2'd0, 16'd4,    8'h81, 1'b1},
    {2'd1, 16'd0,    8'h5A, 1'b1},
    {2'd1, 16'd3,    8'hC3, 1'b1},
    {2'd1, 16'd6,    8'h12, 1'b1},
    {2'd2, 16'd2,    8'h77, 1'b1},
    {2'd2, 16'd5,    8'hE0, 1'b1},
    {2'd3, 16'd1,    8'h09, 1'b1},
    {2'd1, 16'd2,    8'h40, 1'b1},
    {2'd0, 16'd1000, 8'h55, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] tgt_addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic [1:0] method = '0;
  logic busy, done, timeout, rd_valid, rd_ready, rsp_ready;
  logic [AW-1:0] rd_addr;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int cur_n = 0;
  logic [7:0] cur_d = '0;
  logic [AW-1:0] cur_addr = '0;
  logic mclr = 1'b0;

  logic [2:0] bp = '0;
  int mreads = 0;
  int bad_addr = 0;
  int bad_hold = 0;
  logic [1:0] dly = '0;
  logic pv = 1'b0;
  logic [AW-1:0] pa = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eow_poller #(.AW(AW), .DW(DW), .TIMEOUT_CYCLES(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr),
    .exp_data(exp_data), .method(method), .busy(busy), .done(done),
    .timeout(timeout), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  function automatic logic [7:0] dev_byte(int idx, int n, logic [7:0] d);
    if (idx <= n) return {~d[7], (idx % 2 == 1) ? 1'b1 : 1'b0, d[5:0]};
    return d;
  endfunction

  function automatic int ref_reads(int m, int n, logic [7:0] d);
    logic [7:0] prev, cur;
    bit have, cok, pass;
    int phase;
    prev = '0; have = 0; cok = 0; phase = 0;
    for (int k = 1; k < 500; k++) begin
      cur = dev_byte(k, n, d);
      if (m == 0) pass = (cur[7] == d[7]);
      else if (m == 1) pass = (cur[6] == prev[6]);
      else pass = (cur == prev);
      if (phase == 0) begin
        if (m != 0 && !have) have = 1;
        else if (pass) return k;
        else phase = 1;
      end else if (phase == 1) begin
        cok = pass;
        phase = 2;
      end else begin
        if (cok && pass) return k;
        phase = 0;
      end
      prev = cur;
    end
    return -1;
  endfunction

  assign rd_ready = (bp != 3'd5);

  always_ff @(posedge clk) begin
    bp <= bp + 1'b1;
    cycles <= cycles + 1;
    if (!rst_n || mclr) begin
      mreads <= 0;
      rsp_valid <= 1'b0;
      dly <= '0;
    end else begin
      if (rd_valid && rd_ready) begin
        mreads <= mreads + 1;
        rsp_data <= dev_byte(mreads + 1, cur_n, cur_d);
        dly <= 2'd2;
        if (rd_addr != cur_addr) bad_addr <= bad_addr + 1;
      end else if (dly != 0) begin
        dly <= dly - 1'b1;
        if (dly == 2'd1) rsp_valid <= 1'b1;
      end
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    pv <= rd_valid && !rd_ready;
    pa <= rd_addr;
    if (rst_n && pv && !timeout && (!rd_valid || rd_addr != pa))
      bad_hold <= bad_hold + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_model();
    @(negedge clk); mclr = 1'b1;
    @(negedge clk); mclr = 1'b0;
  endtask

  task automatic run_one(input int m, input int n, input logic [7:0] d,
                         input logic [AW-1:0] a, input bit second_start,
                         output bit got_done, output int edges);
    bit seen_t;
    cur_n = n; cur_d = d; cur_addr = a;
    clear_model();
    @(negedge clk);
    tgt_addr = a; exp_data = d; method = 2'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    got_done = 0; seen_t = 0;
    for (int w = 0; w < 2000; w++) begin
      if (done) begin got_done = 1; break; end
      if (timeout) begin seen_t = 1; break; end
      if (second_start && w == 3) begin
        tgt_addr = a ^ 19'h155; exp_data = ~d; method = 2'd1; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      edges++;
    end
    start = 1'b0;
    if (!got_done && !seen_t) check(0, "watchdog", 0, 1);
  endtask

  initial begin
    bit gd;
    int ed, er;
    repeat (3) @(negedge clk);
    check(!busy && !done && !timeout && !rd_valid, "R1 reset outputs", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !rd_valid, "R1 idle after reset", rd_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_one(int'(VECS[i].m), int'(VECS[i].n), VECS[i].d, 19'(32'h1000 + i * 7),
              1'b0, gd, ed);
      check(gd == VECS[i].ok, "R2 R3 R4 R9 outcome", gd, VECS[i].ok);
      check(!busy, "R8 busy low at pulse", busy, 0);
      if (VECS[i].ok) begin
        er = ref_reads(int'(VECS[i].m), int'(VECS[i].n), VECS[i].d);
        check(mreads == er, "R5 read count", mreads, er);
        @(negedge clk);
        check(!done, "R8 done single cycle", done, 0);
      end else begin
        check(ed == LIMIT + 1, "R9 timeout cycle", ed, LIMIT + 1);
        check(!done, "R8 no done with timeout", done, 0);
        @(negedge clk);
        check(!timeout, "R8 timeout single cycle", timeout, 0);
        repeat (10) @(negedge clk);
        check(!rsp_valid, "R7 stray response dropped", rsp_valid, 0);
      end
      repeat (3) @(negedge clk);
    end

    run_one(0, 4, 8'h81, 19'h2AAAA, 1'b1, gd, ed);
    er = ref_reads(0, 4, 8'h81);
    check(gd, "R10 run completes", gd, 1);
    check(mreads == er, "R10 second start ignored", mreads, er);
    check(bad_addr == 0, "R6 address matches target", bad_addr, 0);
    check(bad_hold == 0, "R6 request held until taken", bad_hold, 0);
    check(!rd_valid && !busy, "R1 quiet when idle", rd_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule